// File: doc/BRIEF.md
# Keyed Windowed Watchdog

This block guards a processor against runaway software. Once enabled, it counts clock cycles up to a programmable limit. Software must prove that it is alive by writing a fixed key byte to a refresh port. Each later refresh must land inside a window at the end of the period. A write that is too early, a wrong key, a key delivered by a single-bit read-modify-write, a missed deadline or a stray processor access all end the same way: a one-cycle internal reset request.

Configuration comes from a static byte. The block captures it while the external reset is low and captures it again after every reset request it issues. Changing the byte during normal operation therefore has no effect until the next reset. The address guard compares instruction fetches and data accesses against a permitted range given on two pins. A fixed high area is left open to data accesses only.

Top module: `keyed_window_watchdog`

## Requirements
- R1: Configuration bit 4 (`cfg_byte[4]`) is the enable. When the captured value is 0, the counter holds, refresh writes and address violations are ignored, and `wdt_rst` stays low.
- R2: Configuration bits 3..1 hold an overflow code n. With no accepted refresh, `wdt_rst` is high in cycle 2^(BASE+n) after the counter last restarted from zero.
- R3: A refresh write of key 0xAC that is accepted restarts the counter from zero.
- R4: The first refresh write after any reset is accepted at any counter value, whatever the window code.
- R5: Configuration bits 6..5 hold a window code w. Later refreshes are accepted only when the count is at least P - (w+1)*P/4, where P is the period. A refresh below that count causes a reset request. Code 3 keeps the window always open.
- R6: A refresh write with any data value other than 0xAC causes a reset request.
- R7: A refresh write with `kick_bitop` high causes a reset request, even when the data is 0xAC.
- R8: A valid refresh on the final count P-1 is accepted and prevents the overflow.
- R9: While enabled, an instruction fetch whose address lies outside [`ok_lo`, `ok_hi`] causes a reset request.
- R10: While enabled, a data access outside [`ok_lo`, `ok_hi`] causes a reset request, unless its address is 0xFB00 or higher.
- R11: `wdt_rst` is high for exactly one cycle. On the next edge the block captures `cfg_byte` again, clears the counter and makes the next refresh a first refresh again. Inputs are ignored during the pulse.
- R12: A reset request is registered, so `wdt_rst` rises in the cycle after the offending input or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; captures `cfg_byte` while low |
| cfg_byte | input | 8 | Static configuration byte: bit 4 enable, bits 3..1 overflow code, bits 6..5 window code |
| kick_wr | input | 1 | Refresh register write strobe |
| kick_data | input | 8 | Refresh write data |
| kick_bitop | input | 1 | The refresh write comes from a single-bit manipulation operation |
| fetch_vld | input | 1 | Instruction fetch in this cycle |
| fetch_addr | input | AW | Fetch address |
| dacc_vld | input | 1 | Data read or write in this cycle |
| dacc_addr | input | AW | Data access address |
| ok_lo | input | AW | Lowest permitted address |
| ok_hi | input | AW | Highest permitted address |
| wdt_rst | output | 1 | One-cycle internal reset request |

## Verification
The bench targets several corner cases, and each one catches a specific kind of fault:
- An early second refresh must trip (R5). A design that forgot the window would take it silently.
- The first refresh placed deep in the closed part of the window must pass (R4). A design without the first-write exemption would reset there.
- A refresh on the last count must win over the overflow (R8). An off-by-one in the terminal compare would reset anyway.
- A key of 0xAC delivered as a bit operation must trip (R7). A design that checked only the data would accept it.
- Data accesses just below and inside the exempt high area show whether the exemption is applied only to data accesses (R10).
- Changing the configuration byte mid-run shows whether it is captured only at reset (R11). A live decode would change the period at once.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [7:0] REFRESH_KEY = 8'hAC;

  typedef struct packed {
    logic [1:0] win;
    logic       enable;
    logic [2:0] ovf;
  } wdg_cfg_t;

  function automatic wdg_cfg_t decode_cfg(input logic [7:0] b);
    wdg_cfg_t c;
    c.win    = b[6:5];
    c.enable = b[4];
    c.ovf    = b[3:1];
    return c;
  endfunction
endpackage

// File: rtl/wdg_limits.sv
module wdg_limits #(
  parameter int BASE = 10,
  parameter int CW   = BASE + 8
) (
  input  logic [2:0]    ovf_code,
  input  logic [1:0]    win_code,
  output logic [CW-1:0] last_cnt,
  output logic [CW-1:0] open_from
);
  localparam logic [CW-1:0] BASE_LIMIT = CW'(1) << BASE;

  logic [CW-1:0] limit;
  logic [CW-1:0] quarter;
  logic [CW-1:0] open_len;

  always_comb begin
    limit   = BASE_LIMIT << ovf_code;
    quarter = limit >> 2;
    unique case (win_code)
      2'd0:    open_len = quarter;
      2'd1:    open_len = quarter << 1;
      2'd2:    open_len = quarter + (quarter << 1);
      default: open_len = limit;
    endcase
    last_cnt  = limit - CW'(1);
    open_from = limit - open_len;
  end
endmodule

// File: rtl/wdg_key_check.sv
module wdg_key_check #(
  parameter logic [7:0] KEY = 8'hAC
) (
  input  logic       wr,
  input  logic       bitop,
  input  logic [7:0] data,
  input  logic       armed,
  input  logic       in_window,
  output logic       accept,
  output logic       fault
);
  always_comb begin
    accept = 1'b0;
    fault  = 1'b0;
    if (wr) begin
      if (bitop || (data != KEY) || (armed && !in_window)) fault = 1'b1;
      else accept = 1'b1;
    end
  end
endmodule

// File: rtl/wdg_addr_guard.sv
module wdg_addr_guard #(
  parameter int            AW          = 16,
  parameter bit            DATA_PORT   = 1'b0,
  parameter logic [AW-1:0] EXEMPT_FROM = '1
) (
  input  logic          vld,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic          violation
);
  logic outside;
  logic exempt;

  assign outside = (addr < lo) || (addr > hi);

  generate
    if (DATA_PORT) begin : g_data
      assign exempt = (addr >= EXEMPT_FROM);
    end else begin : g_fetch
      assign exempt = 1'b0;
    end
  endgenerate

  assign violation = vld && outside && !exempt;
endmodule

// File: rtl/keyed_window_watchdog.sv
module keyed_window_watchdog #(
  parameter int            BASE        = 10,
  parameter int            AW          = 16,
  parameter logic [AW-1:0] DATA_EXEMPT = 'hFB00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cfg_byte,
  input  logic          kick_wr,
  input  logic [7:0]    kick_data,
  input  logic          kick_bitop,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  input  logic          dacc_vld,
  input  logic [AW-1:0] dacc_addr,
  input  logic [AW-1:0] ok_lo,
  input  logic [AW-1:0] ok_hi,
  output logic          wdt_rst
);
  import wdg_pkg::*;

  localparam int CW = BASE + 8;

  wdg_cfg_t      cfg_q;
  logic [CW-1:0] cnt_q;
  logic          first_q;
  logic          pulse_q;

  logic          enabled;
  logic          live;
  logic [CW-1:0] last_cnt;
  logic [CW-1:0] open_from;
  logic          in_window;
  logic          at_last;
  logic          key_accept;
  logic          key_fault;
  logic          fetch_bad;
  logic          data_bad;
  logic          trip;

  assign enabled   = cfg_q.enable;
  assign live      = enabled && !pulse_q;
  assign in_window = (cnt_q >= open_from);
  assign at_last   = (cnt_q == last_cnt);

  wdg_limits #(.BASE(BASE), .CW(CW)) u_limits (
    .ovf_code  (cfg_q.ovf),
    .win_code  (cfg_q.win),
    .last_cnt  (last_cnt),
    .open_from (open_from)
  );

  wdg_key_check #(.KEY(REFRESH_KEY)) u_key (
    .wr        (kick_wr && live),
    .bitop     (kick_bitop),
    .data      (kick_data),
    .armed     (first_q),
    .in_window (in_window),
    .accept    (key_accept),
    .fault     (key_fault)
  );

  wdg_addr_guard #(.AW(AW), .DATA_PORT(1'b0), .EXEMPT_FROM(DATA_EXEMPT)) u_fetch_guard (
    .vld       (fetch_vld && live),
    .addr      (fetch_addr),
    .lo        (ok_lo),
    .hi        (ok_hi),
    .violation (fetch_bad)
  );

  wdg_addr_guard #(.AW(AW), .DATA_PORT(1'b1), .EXEMPT_FROM(DATA_EXEMPT)) u_data_guard (
    .vld       (dacc_vld && live),
    .addr      (dacc_addr),
    .lo        (ok_lo),
    .hi        (ok_hi),
    .violation (data_bad)
  );

  assign trip = key_fault || fetch_bad || data_bad ||
                (live && at_last && !key_accept);

  always_ff @(posedge clk) begin
    if (!rst_n || pulse_q) begin
      cfg_q   <= decode_cfg(cfg_byte);
      cnt_q   <= '0;
      first_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= trip;
      if (trip) begin
        cnt_q <= '0;
      end else if (key_accept) begin
        cnt_q   <= '0;
        first_q <= 1'b1;
      end else if (enabled) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign wdt_rst = pulse_q;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int CW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wdt_rst,
  input logic          en_q,
  input logic          first_q,
  input logic          kick_wr,
  input logic          kick_bitop,
  input logic [7:0]    kick_data,
  input logic          fetch_vld,
  input logic          dacc_vld,
  input logic          fetch_bad,
  input logic [CW-1:0] cnt_q
);
  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  p_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> (cnt_q == '0 && !first_q));

  p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wdt_rst) |=> !wdt_rst);

  p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wdt_rst) |=> $stable(cnt_q));

  p_bad_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wdt_rst && kick_wr && kick_data != 8'hAC) |=> wdt_rst);

  p_bitop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wdt_rst && kick_wr && kick_bitop) |=> wdt_rst);

  p_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wdt_rst && fetch_bad) |=> wdt_rst);

  p_first_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wdt_rst && !first_q && kick_wr && !kick_bitop &&
     kick_data == 8'hAC && !fetch_vld && !dacc_vld)
    |=> (!wdt_rst && first_q && cnt_q == '0));
endmodule

bind keyed_window_watchdog wdg_checker #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wdt_rst    (wdt_rst),
  .en_q       (enabled),
  .first_q    (first_q),
  .kick_wr    (kick_wr),
  .kick_bitop (kick_bitop),
  .kick_data  (kick_data),
  .fetch_vld  (fetch_vld),
  .dacc_vld   (dacc_vld),
  .fetch_bad  (fetch_bad),
  .cnt_q      (cnt_q)
);

// File: tb/keyed_window_watchdog_bench.sv
module keyed_window_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 3;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_byte = 8'h00;
  logic kick_wr = 1'b0;
  logic [7:0] kick_data = 8'h00;
  logic kick_bitop = 1'b0;
  logic fetch_vld = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic dacc_vld = 1'b0;
  logic [AW-1:0] dacc_addr = '0;
  logic [AW-1:0] ok_lo = 16'h1000;
  logic [AW-1:0] ok_hi = 16'h7FFF;
  logic wdt_rst;

  keyed_window_watchdog #(.BASE(BASE), .AW(AW)) u_keyed_window_watchdog (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte),
    .kick_wr(kick_wr), .kick_data(kick_data), .kick_bitop(kick_bitop),
    .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .dacc_vld(dacc_vld), .dacc_addr(dacc_addr),
    .ok_lo(ok_lo), .ok_hi(ok_hi), .wdt_rst(wdt_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt = 0;
  bit m_first = 0;
  bit [7:0] m_cfg = 8'h00;
  bit m_rst = 0;

  function automatic [7:0] mk(input bit en, input int ovf, input int win);
    return {1'b0, 2'(win), en, 3'(ovf), 1'b0};
  endfunction

  function automatic void model_edge();
    int lim, open_at;
    bit en, trip, ok;
    if (!rst_n || m_rst) begin
      m_cnt = 0; m_first = 0; m_cfg = cfg_byte; m_rst = 0;
      return;
    end
    en = m_cfg[4];
    lim = 1 << (BASE + int'(m_cfg[3:1]));
    open_at = lim - (lim / 4) * (int'(m_cfg[6:5]) + 1);
    trip = 0; ok = 0;
    if (en) begin
      if (kick_wr) begin
        if (kick_bitop || kick_data != 8'hAC || (m_first && m_cnt < open_at)) trip = 1;
        else ok = 1;
      end
      if (fetch_vld && (fetch_addr < ok_lo || fetch_addr > ok_hi)) trip = 1;
      if (dacc_vld && dacc_addr < 16'hFB00 && (dacc_addr < ok_lo || dacc_addr > ok_hi)) trip = 1;
      if (!ok && m_cnt == lim - 1) trip = 1;
    end
    if (trip) begin m_rst = 1; m_cnt = 0; end
    else if (ok) begin m_cnt = 0; m_first = 1; end
    else if (en) m_cnt++;
  endfunction

  task automatic check(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: wdt_rst actual %0b expected %0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(cur_req, wdt_rst, m_rst);
  endtask

  task automatic wait_cnt(input int c);
    for (int i = 0; i < 5000; i++) begin
      if (!m_rst && m_cnt == c) return;
      step();
    end
  endtask

  task automatic kick(input logic [7:0] d, input logic bop);
    kick_wr = 1'b1; kick_data = d; kick_bitop = bop;
    step();
    kick_wr = 1'b0; kick_bitop = 1'b0;
  endtask

  task automatic fetch(input logic [AW-1:0] a);
    fetch_vld = 1'b1; fetch_addr = a;
    step();
    fetch_vld = 1'b0;
  endtask

  task automatic dacc(input logic [AW-1:0] a);
    dacc_vld = 1'b1; dacc_addr = a;
    step();
    dacc_vld = 1'b0;
  endtask

  task automatic do_reset(input logic [7:0] c);
    @(negedge clk);
    rst_n = 1'b0; cfg_byte = c;
    step(); step();
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    // R1: disabled, nothing trips
    cur_req = "R1";
    do_reset(mk(0, 0, 0));
    check("R1 reset state", wdt_rst, 1'b0);
    kick(8'h11, 1'b0);
    fetch(16'h9000);
    for (int i = 0; i < 40; i++) step();

    // R2/R12: idle overflow with period 8
    cur_req = "R2";
    do_reset(mk(1, 0, 0));
    n = 0;
    for (int i = 0; i < 20 && !wdt_rst; i++) begin step(); n++; end
    checks++;
    if (n != 8) begin
      errors++;
      $display("FAIL R2: pulse cycle actual %0d expected 8", n);
    end
    cur_req = "R11";
    step();
    check("R11 single pulse", wdt_rst, 1'b0);

    // R4/R5 with period 32, window code 0 (open from 24)
    do_reset(mk(1, 2, 0));
    cur_req = "R4";
    wait_cnt(3); kick(8'hAC, 1'b0);
    check("R4 first refresh early", wdt_rst, 1'b0);
    cur_req = "R5";
    wait_cnt(5); kick(8'hAC, 1'b0);
    check("R5 closed window refresh", wdt_rst, 1'b1);
    step();
    cur_req = "R4";
    wait_cnt(2); kick(8'hAC, 1'b0);
    check("R4 rearmed after pulse", wdt_rst, 1'b0);
    cur_req = "R3";
    wait_cnt(26); kick(8'hAC, 1'b0);
    check("R3 refresh in window", wdt_rst, 1'b0);
    cur_req = "R8";
    wait_cnt(31); kick(8'hAC, 1'b0);
    check("R8 refresh on last count", wdt_rst, 1'b0);
    step();
    check("R8 no overflow", wdt_rst, 1'b0);
    cur_req = "R6";
    wait_cnt(28); kick(8'h5A, 1'b0);
    check("R6 wrong key", wdt_rst, 1'b1);
    step();
    cur_req = "R7";
    wait_cnt(1); kick(8'hAC, 1'b1);
    check("R7 bit operation", wdt_rst, 1'b1);
    step();
    cur_req = "R2";
    n = 0;
    for (int i = 0; i < 80 && !wdt_rst; i++) begin step(); n++; end
    checks++;
    if (n != 32) begin
      errors++;
      $display("FAIL R2: pulse cycle actual %0d expected 32", n);
    end
    step();

    // R5: window code 3 always open, period 16
    cur_req = "R5";
    do_reset(mk(1, 1, 3));
    wait_cnt(1); kick(8'hAC, 1'b0);
    wait_cnt(2); kick(8'hAC, 1'b0);
    check("R5 window always open", wdt_rst, 1'b0);

    // R9/R10 address guard
    cur_req = "R9";
    fetch(16'h2000);
    check("R9 fetch inside", wdt_rst, 1'b0);
    fetch(16'h8000);
    check("R9 fetch above range", wdt_rst, 1'b1);
    step();
    fetch(16'hFC00);
    check("R9 fetch in data-exempt area", wdt_rst, 1'b1);
    step();
    cur_req = "R10";
    dacc(16'hFC00);
    check("R10 data exempt area", wdt_rst, 1'b0);
    dacc(16'h3000);
    check("R10 data inside", wdt_rst, 1'b0);
    dacc(16'hFAFF);
    check("R10 data below exempt area", wdt_rst, 1'b1);
    step();
    dacc(16'h0800);
    check("R10 data below range", wdt_rst, 1'b1);
    step();

    // R11: config captured only at reset
    cur_req = "R11";
    do_reset(mk(1, 0, 0));
    cfg_byte = mk(0, 3, 0);
    n = 0;
    for (int i = 0; i < 20 && !wdt_rst; i++) begin step(); n++; end
    checks++;
    if (n != 8) begin
      errors++;
      $display("FAIL R11: pulse cycle actual %0d expected 8", n);
    end
    step();
    cur_req = "R1";
    kick(8'h00, 1'b1);
    fetch(16'h0000);
    for (int i = 0; i < 60; i++) step();
    check("R1 disabled after reload", wdt_rst, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule